// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block sends a fixed identification word, one bit at a time, on the serial data line of a chip-selected serial device. The host selects the device by pulling chip select low and raises the reset pin for a short time. When the pin falls, the block drives the first bit. Every later falling edge of the serial clock moves the line to the next bit. After the last bit the block releases the line and waits for the next qualifying pulse. The word is set by a parameter when the block is built and cannot be changed while it runs.

The chip-select, reset-pin and serial-clock inputs are asynchronous to the system clock. Each one passes through its own synchroniser chain, and edges are found on the synchronised copies. A write-busy flag from the rest of the device, which runs on the system clock, stops a pulse from starting the response while a nonvolatile write is in progress. The block has a data output and an output enable, which drive a tri-state pad. Whenever the enable is low the pad is high-impedance, and a high chip select removes the enable at once.

Top module: `atr_serializer`

## Requirements
- R1: After system reset, `sd_oe_o` and `sd_o` are both 0.
- R2: A rising edge on `rst_pin_i` arms the block when `cs_n_i` is 0 and `wr_busy_i` is 0. The falling edge of the same pulse then starts the response. Within SYNC_STAGES+1 clock cycles of that fall, `sd_oe_o` is 1 and `sd_o` carries bit 0 of PATTERN.
- R3: Each falling edge of `sclk_i` during the response moves the output to the next bit. Bits go out least significant bit first (PATTERN bit i is the i-th bit on the line, counting from 0), so all WIDTH bits of PATTERN appear in order.
- R4: The falling edge of `sclk_i` that follows the last bit (bit WIDTH-1) drops `sd_oe_o` to 0. The block then stays idle until the next qualifying pulse.
- R5: A reset-pin pulse whose rising edge arrives while `wr_busy_i` is 1 starts no response.
- R6: When `cs_n_i` goes to 1 during the response, `sd_oe_o` goes to 0 in the same cycle. The response is abandoned and does not resume when `cs_n_i` returns to 0.
- R7: A reset-pin pulse that rises while `cs_n_i` is 1 starts no response.
- R8: Serial-clock edges while no response is active leave `sd_oe_o` at 0.
- R9: `sd_o` is 0 whenever `sd_oe_o` is 0.
- R10: If `cs_n_i` goes to 1 between the rise and the fall of the reset-pin pulse, the pulse is cancelled and its fall starts no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rst_pin_i | input | 1 | Reset-pin pulse that requests the response, asynchronous |
| sclk_i | input | 1 | Serial clock; its falling edges advance the bit, asynchronous |
| wr_busy_i | input | 1 | Nonvolatile write in progress, synchronous to clk |
| sd_o | output | 1 | Serial data to the pad |
| sd_oe_o | output | 1 | Pad output enable; 0 means high-impedance |

## Verification
Two situations are the hardest to reach from the ports. One is a deselect that lands in the middle of the word. The other is a deselect that falls between the rise and the fall of the reset pulse, and it lasts only a few clock cycles after synchronisation. The bench drives the input pins at chosen falling edges of the system clock so that each event lands in a known cycle. It reads a partial word before pulling chip select high, and it lowers chip select again before the pulse falls to hit the armed window. It also moves the write-busy flag around the rising edge of the pulse. A behavioural model delays the pins by the synchroniser depth and checks both outputs on every clock.

// File: rtl/atr_pkg.sv
package atr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_SHIFT = 2'd2
   } atr_state_e;

   localparam int unsigned PIN_CS   = 2;
   localparam int unsigned PIN_RP   = 1;
   localparam int unsigned PIN_SCK  = 0;
   localparam int unsigned PIN_CNT  = 3;
endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("atr_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("atr_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RESET_VAL;
      else        chain[0] <= d_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= RESET_VAL;
         else        chain[g] <= chain[g-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/atr_edge.sv
module atr_edge #(
   parameter int unsigned  W         = 1,
   parameter logic [W-1:0] RISE_MASK = '0,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] s_i,
   output logic [W-1:0] evt_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RESET_VAL;
      else        prev_q <= s_i;
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (RISE_MASK[b]) begin : g_rise
         assign evt_o[b] = s_i[b] & ~prev_q[b];
      end else begin : g_fall
         assign evt_o[b] = ~s_i[b] & prev_q[b];
      end
   end
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
   import atr_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n_i,
   input  logic             rp_rise_i,
   input  logic             rp_fall_i,
   input  logic             sck_fall_i,
   input  logic             busy_i,
   output logic             shifting_o,
   output logic [IDX_W-1:0] idx_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

   atr_state_e       state_q, state_d;
   logic [IDX_W-1:0] idx_q, idx_d;

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      unique case (state_q)
         ST_IDLE: begin
            if (rp_rise_i && !sel_n_i && !busy_i) state_d = ST_ARMED;
         end
         ST_ARMED: begin
            if (sel_n_i) begin
               state_d = ST_IDLE;
            end else if (rp_fall_i) begin
               state_d = ST_SHIFT;
               idx_d   = '0;
            end
         end
         ST_SHIFT: begin
            if (sel_n_i) begin
               state_d = ST_IDLE;
            end else if (sck_fall_i) begin
               if (idx_q == LAST_IDX) state_d = ST_IDLE;
               else                   idx_d   = idx_q + 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
      end
   end

   assign shifting_o = (state_q == ST_SHIFT);
   assign idx_o      = idx_q;

   // R2: the response is entered only from the armed state, at bit 0
   p_enter_from_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shifting_o) |-> ($past(state_q) == ST_ARMED) && (idx_q == '0));

   // R3: inside a response the bit index only steps by one
   p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shifting_o && $past(shifting_o) && (idx_q != $past(idx_q)))
      |-> (idx_q == $past(idx_q) + 1'b1));

   // R4: the index never runs past the last bit
   p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shifting_o |-> (idx_q <= LAST_IDX));

   // R5: a busy device never becomes armed
   p_no_arm_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARMED && $past(state_q) == ST_IDLE) |-> !$past(busy_i));

   // R6 / R10: deselection returns to idle on the next cycle
   p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/atr_bitsel.sv
module atr_bitsel #(
   parameter int unsigned    WIDTH     = 32,
   parameter logic [WIDTH-1:0] PATTERN = '0,
   parameter bit             LSB_FIRST = 1'b1,
   localparam int unsigned   IDX_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic             bit_o
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

   if (LSB_FIRST) begin : g_lsb
      assign bit_o = PATTERN[idx_i];
   end else begin : g_msb
      assign bit_o = PATTERN[TOP_IDX - idx_i];
   end
endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
   import atr_pkg::*;
#(
   parameter int unsigned      WIDTH       = 32,
   parameter logic [WIDTH-1:0] PATTERN     = 32'hA5C3_1E96,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter bit               LSB_FIRST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic rst_pin_i,
   input  logic sclk_i,
   input  logic wr_busy_i,
   output logic sd_o,
   output logic sd_oe_o
);
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [PIN_CNT-1:0] PIN_RST_VAL = 3'b100;

   if (WIDTH < 2) begin : g_bad_width
      $error("atr_serializer: WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("atr_serializer: SYNC_STAGES must be at least 2");
   end

   logic [PIN_CNT-1:0] pins_s;
   logic [2:0]         evt;
   logic               shifting;
   logic [IDX_W-1:0]   idx;
   logic               cur_bit;

   atr_sync #(
      .STAGES    (SYNC_STAGES),
      .W         (PIN_CNT),
      .RESET_VAL (PIN_RST_VAL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_n_i, rst_pin_i, sclk_i}),
      .q_o   (pins_s)
   );

   // evt[2]: reset-pin rise, evt[1]: reset-pin fall, evt[0]: serial-clock fall
   atr_edge #(
      .W         (3),
      .RISE_MASK (3'b100),
      .RESET_VAL (3'b000)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .s_i   ({pins_s[PIN_RP], pins_s[PIN_RP], pins_s[PIN_SCK]}),
      .evt_o (evt)
   );

   atr_ctrl #(
      .WIDTH (WIDTH)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_n_i    (pins_s[PIN_CS]),
      .rp_rise_i  (evt[2]),
      .rp_fall_i  (evt[1]),
      .sck_fall_i (evt[0]),
      .busy_i     (wr_busy_i),
      .shifting_o (shifting),
      .idx_o      (idx)
   );

   atr_bitsel #(
      .WIDTH     (WIDTH),
      .PATTERN   (PATTERN),
      .LSB_FIRST (LSB_FIRST)
   ) u_bitsel (
      .idx_i (idx),
      .bit_o (cur_bit)
   );

   // the raw select gates the enable so that deselection releases the pad at once
   assign sd_oe_o = shifting & ~cs_n_i;
   assign sd_o    = sd_oe_o & cur_bit;

   // R7: a synchronised deselect keeps the pad released on the following cycle
   p_deselect_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pins_s[PIN_CS] |=> !sd_oe_o);

   // R9: the data pin is low while the pad is released
   p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !shifting |-> !sd_o);
endmodule

// File: tb/atr_serializer_bench.sv
`timescale 1ns/1ps
module atr_serializer_bench;
   localparam int unsigned      WIDTH = 32;
   localparam logic [WIDTH-1:0] PAT   = 32'hA5C3_1E96;
   localparam int unsigned      STG   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, rp = 1'b0, sc = 1'b0, busy = 1'b0;
   logic sd, oe;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   atr_serializer #(.WIDTH(WIDTH), .PATTERN(PAT), .SYNC_STAGES(STG)) u_atr_serializer (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .rst_pin_i(rp), .sclk_i(sc),
      .wr_busy_i(busy), .sd_o(sd), .sd_oe_o(oe));

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic q_cs[$], q_rp[$], q_sc[$];
   int   m_state = 0;   // 0 idle, 1 armed, 2 sending
   int   m_bit = 0;

   function automatic void model_clear();
      q_cs = {}; q_rp = {}; q_sc = {};
      for (int i = 0; i <= STG; i++) begin
         q_cs.push_back(1'b1); q_rp.push_back(1'b0); q_sc.push_back(1'b0);
      end
      m_state = 0; m_bit = 0;
   endfunction

   initial model_clear();

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         model_clear();
      end else begin
         logic s_cs, s_rp, p_rp, s_sc, p_sc;
         s_cs = q_cs[STG-1];
         s_rp = q_rp[STG-1]; p_rp = q_rp[STG];
         s_sc = q_sc[STG-1]; p_sc = q_sc[STG];
         case (m_state)
            0: if (s_rp && !p_rp && !s_cs && !busy) m_state = 1;
            1: if (s_cs) m_state = 0;
               else if (!s_rp && p_rp) begin m_state = 2; m_bit = 0; end
            default: if (s_cs) m_state = 0;
               else if (!s_sc && p_sc) begin
                  if (m_bit == WIDTH-1) m_state = 0;
                  else m_bit++;
               end
         endcase
         q_cs.push_front(cs_n); void'(q_cs.pop_back());
         q_rp.push_front(rp);   void'(q_rp.pop_back());
         q_sc.push_front(sc);   void'(q_sc.pop_back());
      end
      #1;
      if (rst_n && !done) begin
         logic e_oe, e_sd;
         e_oe = (m_state == 2) && !cs_n;
         e_sd = e_oe && PAT[m_bit];
         tests++;
         if (oe !== e_oe || sd !== e_sd) begin
            fails++;
            $display("FAIL %s model cycle %0d actual oe=%b sd=%b expected oe=%b sd=%b",
                     cur_req, cycles, oe, sd, e_oe, e_sd);
         end
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_rp();
      rp = 1'b1; cyc(4); rp = 1'b0; cyc(STG + 3);
   endtask

   task automatic sck_fall();
      sc = 1'b1; cyc(4); sc = 1'b0; cyc(STG + 3);
   endtask

   task automatic read_word(string req, output logic [31:0] w);
      w = '0;
      chk(req, "enable at bit 0", 32'(oe), 32'd1);
      w[0] = sd;
      for (int i = 1; i < WIDTH; i++) begin
         sck_fall();
         chk(req, "enable during word", 32'(oe), 32'd1);
         w[i] = sd;
      end
   endtask

   initial begin
      logic [31:0] word;
      cyc(3);
      // R1 and R9 reset state
      cur_req = "R1";
      chk("R1", "oe in reset", 32'(oe), 32'd0);
      chk("R9", "sd in reset", 32'(sd), 32'd0);
      rst_n = 1'b1;
      cyc(4);
      chk("R1", "oe after reset", 32'(oe), 32'd0);

      // R8: serial clock while idle
      cur_req = "R8";
      cs_n = 1'b0; cyc(4);
      for (int k = 0; k < 3; k++) begin
         sck_fall();
         chk("R8", "oe idle clocking", 32'(oe), 32'd0);
         chk("R9", "sd idle clocking", 32'(sd), 32'd0);
      end

      // R2, R3, R4: full word
      cur_req = "R3";
      pulse_rp();
      chk("R2", "first bit", 32'(sd), 32'(PAT[0]));
      read_word("R3", word);
      chk("R3", "full word LSB first", word, PAT);
      sck_fall();
      chk("R4", "oe after last bit", 32'(oe), 32'd0);
      sck_fall();
      chk("R4", "stays idle", 32'(oe), 32'd0);

      // R5: busy at the rising edge
      cur_req = "R5";
      busy = 1'b1; rp = 1'b1; cyc(4); busy = 1'b0; rp = 1'b0; cyc(STG + 3);
      chk("R5", "busy blocks start", 32'(oe), 32'd0);
      sck_fall();
      chk("R5", "busy blocks later", 32'(oe), 32'd0);

      // R7: pulse while deselected
      cur_req = "R7";
      cs_n = 1'b1; cyc(3); rp = 1'b1; cyc(4); cs_n = 1'b0; cyc(STG + 2); rp = 1'b0; cyc(STG + 3);
      chk("R7", "deselected pulse ignored", 32'(oe), 32'd0);

      // R10: deselect between rise and fall
      cur_req = "R10";
      rp = 1'b1; cyc(STG + 3); cs_n = 1'b1; cyc(2); cs_n = 1'b0; cyc(STG + 2);
      rp = 1'b0; cyc(STG + 3);
      chk("R10", "cancelled while armed", 32'(oe), 32'd0);

      // R6: abort mid-word
      cur_req = "R6";
      pulse_rp();
      for (int i = 1; i < 6; i++) sck_fall();
      chk("R6", "bit 5 before abort", 32'(sd), 32'(PAT[5]));
      cs_n = 1'b1; #1;
      chk("R6", "oe drops same cycle", 32'(oe), 32'd0);
      cyc(STG + 3); cs_n = 1'b0; cyc(STG + 3);
      chk("R6", "no resume", 32'(oe), 32'd0);
      sck_fall();
      chk("R6", "clock after abort", 32'(oe), 32'd0);

      // R2 again after abort
      cur_req = "R2";
      pulse_rp();
      chk("R2", "restart bit 0", 32'(sd), 32'(PAT[0]));
      read_word("R3", word);
      chk("R3", "second word", word, PAT);
      sck_fall();
      chk("R4", "end of second word", 32'(oe), 32'd0);

      cyc(5);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule